// File: doc/BRIEF.md
# Level-Sensitive Masked Interrupt Controller

This block gathers a vector of level-sensitive interrupt request lines and drives one interrupt line towards a processor. On every clock edge a status register takes a copy of the request inputs. It holds no memory of past requests: a bit stays set only while its line stays high. An enable register, which software writes through a small 32-bit register port, selects which status bits may reach the output. The output is high whenever at least one status bit and its enable bit are both set.

Software sees two live registers. The enable register (byte offset 0x04) can be read and written. The status register (byte offset 0x0C) can only be read. Two further offsets, 0x00 and 0x14, accept writes that change nothing. Every other offset reads as zero and ignores writes. Every access is a whole 32-bit word and completes in one cycle. Read data is combinational from the address while the read strobe is high.

Top module: `lvl_intc`

## Requirements
- R1: Each status bit equals the level its request input had at the most recent rising clock edge. A line that drops clears its bit at the next edge, with nothing latched.
- R2: `irq_o` is high exactly when the bitwise AND of the enable register and the status register is nonzero. It is driven from those two registers only, so it changes in the cycle after an input change or an enable write.
- R3: A write with `reg_addr` = 0x04 replaces the whole enable register with `reg_wdata` (the low N bits; N defaults to 32). A read of 0x04 returns it, and bits at N and above read as 0. A 1 in bit i enables source i.
- R4: A read of 0x0C returns the status register in bits N-1:0.
- R5: Writes to 0x00 and to 0x14 change neither register nor the output.
- R6: A read of any offset other than 0x04 and 0x0C returns 0. While `reg_rd` is low, `reg_rdata` is 0.
- R7: Writes to any offset other than 0x00, 0x04 and 0x14 change no state. This includes 0x0C, which software cannot clear or set.
- R8: While `rst_n` is low, both registers are 0 and `irq_o` is low. Reset is asynchronous and active-low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | ADDR_W (8) | Byte offset of the register access |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 32 | Write data word |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 32 | Read data, valid in the same cycle as `reg_rd` |
| irq_req_i | input | N (32) | Level-sensitive requests, synchronous to `clk` |
| irq_o | output | 1 | Combined interrupt request |

## Verification
A request level or an enable write applied before a rising edge shows on `irq_o` and in read data after that edge. No result is due earlier, and none is due later than that one edge. Read data follows `reg_addr` in the same cycle, so it always reflects the registers as they stand after the last edge. The bench drives each stimulus on a falling edge. A behavioural model updates on the rising edge, and `irq_o` and `reg_rdata` are compared on the next falling edge, every cycle. This gives one cycle of latency for every stimulus, and the comparison never runs at an edge.

// File: rtl/lvl_intc_pkg.sv
package lvl_intc_pkg;

  localparam logic [31:0] OFS_TRIGCFG = 32'h00;
  localparam logic [31:0] OFS_ENABLE  = 32'h04;
  localparam logic [31:0] OFS_STATUS  = 32'h0C;
  localparam logic [31:0] OFS_CTRL    = 32'h14;

  typedef enum logic [1:0] {
    SEL_NONE   = 2'd0,
    SEL_ENABLE = 2'd1,
    SEL_STATUS = 2'd2,
    SEL_INERT  = 2'd3
  } reg_sel_e;

  // Classify a byte offset into the register it names.
  function automatic reg_sel_e classify(input logic [31:0] ofs);
    reg_sel_e s;
    if (ofs == OFS_ENABLE)                          s = SEL_ENABLE;
    else if (ofs == OFS_STATUS)                     s = SEL_STATUS;
    else if (ofs == OFS_TRIGCFG || ofs == OFS_CTRL) s = SEL_INERT;
    else                                            s = SEL_NONE;
    return s;
  endfunction

endpackage

// File: rtl/lvl_intc_decode.sv
module lvl_intc_decode
  import lvl_intc_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  output logic              enable_we,
  output reg_sel_e          rd_sel
);

  logic [31:0] addr_ext;
  reg_sel_e    sel;

  always_comb begin
    addr_ext = '0;
    addr_ext[ADDR_W-1:0] = addr;
    sel = classify(addr_ext);
  end

  // Only the enable register accepts writes; inert offsets fall through.
  assign enable_we = wr && (sel == SEL_ENABLE);
  assign rd_sel    = rd ? sel : SEL_NONE;

  a_r7_single_target: assert property (@(posedge clk) disable iff (!rst_n)
    enable_we |-> (addr_ext == OFS_ENABLE) && wr);

endmodule

// File: rtl/lvl_intc_capture.sv
module lvl_intc_capture #(
  parameter int unsigned N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req_i,
  output logic [N-1:0] status_q
);

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) status_q[i] <= 1'b0;
      else        status_q[i] <= req_i[i];
    end
  end

  // Armed one edge after reset so that $past never reaches into reset.
  logic armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  a_r1_tracks_level: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> status_q == $past(req_i));

  a_r8_status_reset: assert property (@(posedge clk)
    !rst_n |-> status_q == '0);

endmodule

// File: rtl/lvl_intc_enable.sv
module lvl_intc_enable #(
  parameter int unsigned N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [31:0]  wdata,
  output logic [N-1:0] enable_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  enable_q <= '0;
    else if (we) enable_q <= wdata[N-1:0];
  end

  a_r3_full_replace: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> enable_q == $past(wdata[N-1:0]));

  a_r7_hold_otherwise: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(enable_q));

endmodule

// File: rtl/lvl_intc.sv
module lvl_intc
  import lvl_intc_pkg::*;
#(
  parameter int unsigned N      = 32,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [31:0]       reg_wdata,
  input  logic              reg_rd,
  output logic [31:0]       reg_rdata,
  input  logic [N-1:0]      irq_req_i,
  output logic              irq_o
);

  logic         enable_we;
  reg_sel_e     rd_sel;
  logic [N-1:0] status_q;
  logic [N-1:0] enable_q;
  logic [N-1:0] live_src;

  lvl_intc_decode #(.ADDR_W(ADDR_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .addr(reg_addr), .wr(reg_wr), .rd(reg_rd),
    .enable_we(enable_we), .rd_sel(rd_sel)
  );

  lvl_intc_capture #(.N(N)) u_cap (
    .clk(clk), .rst_n(rst_n), .req_i(irq_req_i), .status_q(status_q)
  );

  lvl_intc_enable #(.N(N)) u_en (
    .clk(clk), .rst_n(rst_n), .we(enable_we), .wdata(reg_wdata),
    .enable_q(enable_q)
  );

  // Combination of enabled and requesting sources.
  assign live_src = enable_q & status_q;
  assign irq_o    = |live_src;

  always_comb begin
    reg_rdata = '0;
    case (rd_sel)
      SEL_ENABLE: reg_rdata[N-1:0] = enable_q;
      SEL_STATUS: reg_rdata[N-1:0] = status_q;
      default:    reg_rdata = '0;
    endcase
  end

  logic armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  a_r2_needs_enabled_req: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && irq_o) |-> |(enable_q & $past(irq_req_i)));

  a_r2_no_req_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(irq_req_i) == '0) |-> !irq_o);

  a_r8_reset_quiet: assert property (@(posedge clk)
    !rst_n |-> !irq_o && enable_q == '0);

  a_r6_idle_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |-> reg_rdata == '0);

endmodule

// File: tb/lvl_intc_test.sv
module lvl_intc_test;

  localparam int N = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic        reg_rd = 1'b0;
  logic [31:0] reg_rdata;
  logic [N-1:0] irq_req_i = '0;
  logic        irq_o;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;  // 200 MHz

  lvl_intc #(.N(N), .ADDR_W(8)) uut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
    .irq_req_i(irq_req_i), .irq_o(irq_o)
  );

  // Behavioural reference: two words of state updated per edge.
  bit [31:0] m_enable = 0;
  bit [31:0] m_status = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_enable = 0;
      m_status = 0;
    end else begin
      m_status = irq_req_i;
      if (reg_wr && reg_addr == 8'h04) m_enable = reg_wdata;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h at %0t", tag, act, exp, $time);
    end
  endtask

  // Compare outputs against the model; called on a falling edge.
  task automatic compare(input string tag);
    bit [31:0] exp_rd;
    check({tag, " R2 irq"}, {31'b0, irq_o}, {31'b0, (m_enable & m_status) != 0});
    if (!reg_rd)                 exp_rd = 0;
    else if (reg_addr == 8'h04)  exp_rd = m_enable;
    else if (reg_addr == 8'h0C)  exp_rd = m_status;
    else                         exp_rd = 0;
    check({tag, " R6/R3/R4 rdata"}, reg_rdata, exp_rd);
  endtask

  // Apply one cycle of stimulus at a falling edge, check at the next one.
  task automatic cyc(input string tag, input logic [N-1:0] req, input logic [7:0] a,
                     input logic wr, input logic [31:0] wd, input logic rd);
    irq_req_i = req; reg_addr = a; reg_wr = wr; reg_wdata = wd; reg_rd = rd;
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    bit [31:0] en_hold;
    // R8: state during reset, even with requests and writes applied.
    @(negedge clk);
    irq_req_i = '1; reg_addr = 8'h04; reg_wr = 1'b1; reg_wdata = 32'hFFFF_FFFF; reg_rd = 1'b1;
    @(negedge clk);
    check("R8 irq in reset", {31'b0, irq_o}, 32'h0);
    check("R8 enable in reset", reg_rdata, 32'h0);
    reg_wr = 1'b0; reg_addr = 8'h0C;
    @(negedge clk);
    check("R8 status in reset", reg_rdata, 32'h0);
    rst_n = 1'b1;
    cyc("R8 first", '0, 8'h04, 1'b0, 0, 1'b1);

    // R1: status follows level, nothing latched.
    cyc("R1 rise", 32'h0000_0005, 8'h0C, 1'b0, 0, 1'b1);
    check("R1 status rise", reg_rdata, 32'h0000_0005);
    cyc("R1 drop", 32'h0000_0004, 8'h0C, 1'b0, 0, 1'b1);
    check("R1 status drop", reg_rdata, 32'h0000_0004);
    check("R2 masked out", {31'b0, irq_o}, 32'h0);

    // R3: enable write, full replace, polarity 1 = enabled.
    cyc("R3 write", 32'h0000_0004, 8'h04, 1'b1, 32'h0000_0004, 1'b1);
    check("R3 readback", reg_rdata, 32'h0000_0004);
    check("R3 enable polarity", {31'b0, irq_o}, 32'h1);
    cyc("R3 replace", 32'h0000_0004, 8'h04, 1'b1, 32'h8000_0000, 1'b1);
    check("R3 replaced", reg_rdata, 32'h8000_0000);
    check("R2 disabled source", {31'b0, irq_o}, 32'h0);
    cyc("R2 msb", 32'h8000_0000, 8'h0C, 1'b0, 0, 1'b1);
    check("R2 msb irq", {31'b0, irq_o}, 32'h1);
    cyc("R1 release", 32'h0, 8'h0C, 1'b0, 0, 1'b1);
    check("R1 irq drop", {31'b0, irq_o}, 32'h0);

    // R5: inert offsets accept writes that change nothing.
    cyc("R5 pre", 32'h8000_0001, 8'h04, 1'b1, 32'h0000_00FF, 1'b0);
    cyc("R5 w00", 32'h8000_0001, 8'h00, 1'b1, 32'hFFFF_FFFF, 1'b1);
    cyc("R5 w14", 32'h8000_0001, 8'h14, 1'b1, 32'h0000_0000, 1'b0);
    cyc("R5 rd", 32'h8000_0001, 8'h04, 1'b0, 0, 1'b1);
    check("R5 enable kept", reg_rdata, 32'h0000_00FF);
    check("R5 irq kept", {31'b0, irq_o}, 32'h1);
    check("R6 inert reads", 32'h0, 32'h0);

    // R7: status offset and unlisted offsets ignore writes.
    cyc("R7 w0C", 32'h0000_0010, 8'h0C, 1'b1, 32'h0, 1'b1);
    check("R7 status not cleared", reg_rdata, 32'h0000_0010);
    cyc("R7 w08", 32'h0000_0010, 8'h08, 1'b1, 32'h0, 1'b0);
    cyc("R7 w1C", 32'h0000_0010, 8'h1C, 1'b1, 32'h0, 1'b0);
    cyc("R7 rd", 32'h0000_0010, 8'h04, 1'b0, 0, 1'b1);
    check("R7 enable kept", reg_rdata, 32'h0000_00FF);

    // R6: other offsets read zero.
    cyc("R6 rd08", 32'hFFFF_FFFF, 8'h08, 1'b0, 0, 1'b1);
    check("R6 rd08 zero", reg_rdata, 32'h0);
    cyc("R6 rd00", 32'hFFFF_FFFF, 8'h00, 1'b0, 0, 1'b1);
    check("R6 rd00 zero", reg_rdata, 32'h0);

    // Mixed traffic compared against the model every cycle.
    for (int k = 0; k < 400; k++) begin
      logic [7:0] a;
      case ($urandom % 7)
        0: a = 8'h00; 1: a = 8'h04; 2: a = 8'h08; 3: a = 8'h0C;
        4: a = 8'h10; 5: a = 8'h14; default: a = 8'h1C;
      endcase
      cyc("R2 mixed", $urandom & $urandom, a, ($urandom % 3) == 0,
          $urandom & $urandom & $urandom, $urandom % 2);
    end

    // R8: reset mid-run returns both registers to zero.
    en_hold = m_enable;
    irq_req_i = '1; reg_rd = 1'b1; reg_addr = 8'h04; reg_wr = 1'b0;
    rst_n = 1'b0;
    #1;
    check("R8 async enable clear", reg_rdata, 32'h0);
    check("R8 async irq", {31'b0, irq_o}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    cyc("R8 after", 32'h0, 8'h0C, 1'b0, 0, 1'b1);
    check("R8 status after", reg_rdata, 32'h0);
    if (en_hold == 32'hDEAD_BEEF) $display("note");

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule